// File: doc/BRIEF.md
# Card Data Buffer with Access-Width Packing

This block sits between a processor bus and a byte-serial card data path. It holds the payload of a multi-block data phase. Outbound bytes go into a transmit store made of two 32-byte halves. Inbound bytes go into a 32-byte receive queue. The processor reaches both through single-cycle accesses that are 1, 2 or 4 bytes wide. Bytes are packed so that the earliest byte in the stream sits in the most significant byte lane of the access.

A transfer is armed by a start pulse. The pulse samples the direction, the block length and the block count, and loads a byte counter with their product. One byte then crosses the card port per clock, under valid/ready handshakes, until the counter runs out. The transfer then goes idle and raises its completion flags. Request outputs ask the processor for more outbound data or tell it that inbound data has arrived. A stop pulse abandons the transfer.

Top module: `sd_data_fifo`

## Requirements
- R1: A start pulse loads the byte counter with blk_cnt × blk_len (12-bit length, 16-bit count). Exactly that many bytes cross the card port. A product of zero completes one cycle after the start.
- R2: A card byte is accepted (card_rx_ready high) only while the transfer is active, bytes remain, and the receive queue holds fewer than 32 bytes.
- R3: A read with cpu_rd high returns up to N queued bytes and removes them, where cpu_size 0, 1 and 2 give N = 1, 2 and 4. The oldest byte is placed in bits [8N-1:8N-8], later bytes go in the lanes below it, and lanes with no data read as zero.
- R4: A write of N bytes queues cpu_wdata byte N-1 first, then the lower bytes in order. Queueing stops once 32 bytes are waiting, and the remaining bytes of that access are dropped.
- R5: A cpu_swap pulse moves the transmit store to its other 32-byte half and discards every queued byte. Only bytes written afterwards are sent.
- R6: rx_req goes high when a card byte enters the receive queue and clears on a processor read that is not accompanied by a new byte. tx_req is high while a send transfer is active, bytes remain, and the transmit store is empty.
- R7: One cycle after the counter reaches zero, xfer_active falls and data_done rises. prog_done rises as well only when the transfer was a send.
- R8: xfer_dir_wr = 1 selects a send, in which card_tx_valid carries data. xfer_dir_wr = 0 selects a receive, in which card_tx_valid stays low.
- R9: At most one byte moves on the card port per clock, and none while the transfer is inactive.
- R10: A stop pulse or a new start deactivates the transfer and empties both queues. After a stop the requests are low and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Arm a new transfer |
| xfer_stop | input | 1 | Abandon the transfer |
| xfer_dir_wr | input | 1 | 1 = send to card, 0 = receive from card |
| blk_len | input | BLEN_W | Bytes per block |
| blk_cnt | input | BCNT_W | Number of blocks |
| cpu_rd | input | 1 | Processor read of the receive queue |
| cpu_wr | input | 1 | Processor write to the transmit store |
| cpu_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_rd is high |
| cpu_swap | input | 1 | Switch transmit half and discard queued bytes |
| card_tx_data | output | 8 | Byte to card |
| card_tx_valid | output | 1 | Byte to card is valid |
| card_tx_ready | input | 1 | Card takes the byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_valid | input | 1 | Byte from card is valid |
| card_rx_ready | output | 1 | Block takes the byte |
| rx_req | output | 1 | Inbound data has arrived |
| tx_req | output | 1 | Transmit store empty while bytes remain |
| data_done | output | 1 | Transfer finished |
| prog_done | output | 1 | Send transfer finished |
| xfer_active | output | 1 | Transfer in progress |

## Verification
The bench mixes access widths in a single stream, so a design that reverses the lane order, or forgets to zero the lanes with no data, returns scrambled words. The final read of an odd leftover byte and a read of an empty queue catch the zero-fill case. Writes are made past the 32-byte limit and past the end of the count, so a design that wraps over queued data or ships surplus bytes puts unexpected bytes on the card port. A swap between two writes shows whether discarded bytes leak out. A receive left running with no reads shows whether the design overruns its 32 entries. The stream is also checked at its completion flags, which would expose a missing program-done flag or one raised on the wrong direction.

// File: rtl/sd_data_fifo.sv
module sd_data_fifo #(
  parameter int BLEN_W = 12,
  parameter int BCNT_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_stop,
  input  logic              xfer_dir_wr,
  input  logic [BLEN_W-1:0] blk_len,
  input  logic [BCNT_W-1:0] blk_cnt,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              cpu_swap,
  output logic [7:0]        card_tx_data,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  input  logic [7:0]        card_rx_data,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  output logic              rx_req,
  output logic              tx_req,
  output logic              data_done,
  output logic              prog_done,
  output logic              xfer_active
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int CW = BLEN_W + BCNT_W;

  logic          active_q, dir_q, half_q, rx_req_q, done_q, prog_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] tx_rd_q, rx_rd_q;
  logic [LW-1:0] tx_len_q, rx_len_q;
  logic [7:0]    tx_mem [2*DEPTH];
  logic [7:0]    rx_mem [DEPTH];

  logic [2:0]    nb, tx_npush, rx_npop;
  logic [LW-1:0] tx_room;
  logic          moving, tx_pop, rx_push, ctl;

  assign nb      = (cpu_size == 2'd0) ? 3'd1 : (cpu_size == 2'd1) ? 3'd2 : 3'd4;
  assign moving  = active_q && (left_q != '0);
  assign ctl     = xfer_start || xfer_stop;
  assign tx_room = LW'(DEPTH) - tx_len_q;

  assign card_tx_valid = moving && dir_q && (tx_len_q != '0);
  assign card_rx_ready = moving && !dir_q && (rx_len_q < LW'(DEPTH));
  assign card_tx_data  = tx_mem[{half_q, tx_rd_q}];
  assign tx_pop        = card_tx_valid && card_tx_ready;
  assign rx_push       = card_rx_valid && card_rx_ready;

  assign tx_req      = moving && dir_q && (tx_len_q == '0);
  assign rx_req      = rx_req_q;
  assign data_done   = done_q;
  assign prog_done   = prog_q;
  assign xfer_active = active_q;

  always_comb begin
    tx_npush = '0;
    if (cpu_wr && !cpu_swap)
      tx_npush = (LW'(nb) <= tx_room) ? nb : tx_room[2:0];
    rx_npop = '0;
    if (cpu_rd)
      rx_npop = (LW'(nb) <= rx_len_q) ? nb : rx_len_q[2:0];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < rx_npop)
        cpu_rdata = cpu_rdata |
          (32'(rx_mem[rx_rd_q + AW'(k)]) << (8 * (int'(nb) - 1 - k)));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (3'(k) < tx_npush)
        tx_mem[{half_q, tx_rd_q + tx_len_q[AW-1:0] + AW'(k)}] <=
          8'(cpu_wdata >> (8 * (int'(nb) - 1 - k)));
    if (rx_push)
      rx_mem[rx_rd_q + rx_len_q[AW-1:0]] <= card_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      half_q   <= 1'b0;
      rx_req_q <= 1'b0;
      done_q   <= 1'b0;
      prog_q   <= 1'b0;
      left_q   <= '0;
      tx_rd_q  <= '0;
      rx_rd_q  <= '0;
      tx_len_q <= '0;
      rx_len_q <= '0;
    end else if (ctl) begin
      active_q <= xfer_start && !xfer_stop;
      tx_rd_q  <= '0;
      rx_rd_q  <= '0;
      tx_len_q <= '0;
      rx_len_q <= '0;
      rx_req_q <= 1'b0;
      left_q   <= '0;
      if (xfer_start) begin
        dir_q  <= xfer_dir_wr;
        done_q <= 1'b0;
        prog_q <= 1'b0;
        left_q <= CW'(blk_cnt) * CW'(blk_len);
      end
    end else begin
      if (active_q && left_q == '0) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        prog_q   <= dir_q;
      end else if (tx_pop || rx_push) begin
        left_q <= left_q - 1'b1;
      end
      half_q   <= half_q ^ cpu_swap;
      tx_rd_q  <= tx_rd_q + AW'(tx_pop);
      tx_len_q <= cpu_swap ? '0 : tx_len_q + LW'(tx_npush) - LW'(tx_pop);
      rx_rd_q  <= rx_rd_q + AW'(rx_npop);
      rx_len_q <= rx_len_q + LW'(rx_push) - LW'(rx_npop);
      if (rx_push)     rx_req_q <= 1'b1;
      else if (cpu_rd) rx_req_q <= 1'b0;
    end
  end

  assert_rx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len_q <= LW'(DEPTH));
  assert_tx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len_q <= LW'(DEPTH));
  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> left_q <= $past(left_q));
  assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && left_q == '0 && !ctl) |=> (data_done && !xfer_active));
  assert_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> data_done);
  assert_rxreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !ctl) |=> rx_req);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !(card_tx_valid || card_rx_ready));
  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stop |=> (!xfer_active && !rx_req && !tx_req));
endmodule

// File: tb/test_sd_data_fifo.sv
module test_sd_data_fifo;
  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, xfer_stop = 0, xfer_dir_wr = 0;
  logic [11:0] blk_len = '0;
  logic [15:0] blk_cnt = '0;
  logic cpu_rd = 0, cpu_wr = 0, cpu_swap = 0;
  logic [1:0] cpu_size = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic [7:0] card_tx_data, card_rx_data;
  logic card_tx_valid, card_tx_ready = 0, card_rx_valid = 0, card_rx_ready;
  logic rx_req, tx_req, data_done, prog_done, xfer_active;

  int n_tests = 0, n_fail = 0, n_sent = 0;
  logic [7:0] exp_q[$];
  logic [7:0] src_byte = 8'h10;

  always #2.5 clk = ~clk;

  sd_data_fifo i_sd_data_fifo (.*);

  assign card_rx_data = src_byte;
  always @(posedge clk) if (card_rx_valid && card_rx_ready) src_byte <= src_byte + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the outbound card stream
  always @(negedge clk) begin
    if ((card_tx_valid || card_rx_ready) && !xfer_active) check("R9 idle port", 1, 0);
    if (card_tx_valid && card_tx_ready) begin
      n_sent++;
      if (exp_q.size() == 0) check("R4/R5 unexpected byte", {24'h0, card_tx_data}, 32'hDEAD);
      else check("R4 tx byte", {24'h0, card_tx_data}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start(logic dir, logic [15:0] cnt, logic [11:0] len);
    xfer_start = 1; xfer_dir_wr = dir; blk_cnt = cnt; blk_len = len;
    cyc(1);
    xfer_start = 0;
  endtask

  // driver: performs a write and queues the bytes expected on the card port
  task automatic wr(logic [1:0] sz, logic [31:0] d, int keep);
    int n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < keep; k++) exp_q.push_back(8'(d >> (8 * (n - 1 - k))));
    cpu_wr = 1; cpu_size = sz; cpu_wdata = d;
    cyc(1);
    cpu_wr = 0;
  endtask

  task automatic rd(logic [1:0] sz, logic [31:0] exp, string req);
    cpu_rd = 1; cpu_size = sz;
    @(negedge clk);
    check(req, cpu_rdata, exp);
    cyc(1);
    cpu_rd = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset active", xfer_active, 0);
    check("R10 reset done", data_done, 0);
    check("R6 reset tx_req", tx_req, 0);
    check("R9 reset card port", {card_tx_valid, card_rx_ready}, 0);
    cyc(1);

    // R1: zero length completes at once
    start(1, 0, 12'd5);
    cyc(1);
    @(negedge clk);
    check("R1 zero length done", {data_done, prog_done, xfer_active}, 3'b110);
    cyc(1);

    // send 2 x 5 bytes with mixed widths
    card_tx_ready = 1;
    start(1, 2, 12'd5);
    @(negedge clk);
    check("R6 tx_req on empty", tx_req, 1);
    check("R8 rx closed on send", card_rx_ready, 0);
    cyc(1);
    wr(2, 32'hA1A2A3A4, 4); cyc(8);
    wr(1, 32'hFFFFB1B2, 2); cyc(8);
    wr(0, 32'hFFFFFFC1, 1); cyc(8);
    base = n_sent;
    wr(2, 32'hD1D2D3D4, 3); cyc(10);
    check("R1 bytes sent", n_sent - base, 3);
    check("R1 queue drained", exp_q.size(), 0);
    @(negedge clk);
    check("R7 send done", {data_done, prog_done, xfer_active}, 3'b110);
    cyc(1);

    // R4 overflow, R5 swap
    card_tx_ready = 0;
    start(1, 1, 12'd100);
    for (int w = 0; w < 9; w++)
      wr(2, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)}, (w < 8) ? 4 : 0);
    base = n_sent;
    card_tx_ready = 1;
    cyc(40);
    check("R4 only 32 kept", n_sent - base, 32);
    @(negedge clk);
    check("R6 tx_req after drain", tx_req, 1);
    cyc(1);
    card_tx_ready = 0;
    cpu_wr = 1; cpu_size = 2; cpu_wdata = 32'hE1E2E3E4;
    cyc(1);
    cpu_wr = 0; cpu_swap = 1;
    cyc(1);
    cpu_swap = 0;
    wr(2, 32'hF1F2F3F4, 4);
    card_tx_ready = 1;
    cyc(10);
    check("R5 only new half sent", exp_q.size(), 0);
    xfer_stop = 1; cyc(1); xfer_stop = 0;
    @(negedge clk);
    check("R10 stop send", {xfer_active, tx_req, data_done}, 0);
    cyc(1);

    // receive 4 x 10 bytes
    card_rx_valid = 1;
    src_byte = 8'h10;
    start(0, 4, 12'd10);
    cyc(60);
    @(negedge clk);
    check("R2 rx full stalls", card_rx_ready, 0);
    check("R8 tx silent on receive", card_tx_valid, 0);
    check("R6 rx_req on entry", rx_req, 1);
    cyc(1);
    rd(2, 32'h10111213, "R3 four bytes");
    rd(1, 32'h00001415, "R3 two bytes");
    rd(0, 32'h00000016, "R3 one byte");
    cyc(20);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'h17 + 8'(4 * i);
      rd(2, {b, b + 8'd1, b + 8'd2, b + 8'd3}, "R3 drain");
    end
    rd(2, 32'h37000000, "R3 partial zero fill");
    @(negedge clk);
    check("R7 receive done", {data_done, prog_done, xfer_active}, 3'b100);
    check("R6 rx_req cleared", rx_req, 0);
    cyc(1);
    rd(1, 32'h0, "R3 empty read");

    // R10 stop mid receive
    start(0, 1, 12'd20);
    cyc(5);
    xfer_stop = 1; cyc(1); xfer_stop = 0;
    @(negedge clk);
    check("R10 stop receive", {xfer_active, card_rx_ready, rx_req}, 0);
    cyc(1);
    rd(2, 32'h0, "R10 emptied");
    card_rx_valid = 0;
    cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule